// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers five interrupt sources and presents a single pending request, `irq_o`, to the processor core. With the request it gives the 16-bit address of the service routine on `vector_o`. The five sources are:

- a non-maskable trap;
- three restart lines at levels 5.5, 6.5 and 7.5, each with its own mask bit;
- a general request line, whose vector comes from a 3-bit restart number on the bus.

Every maskable source is gated by one global enable bit. Two command pulses control that bit: an enable command sets it and a disable command clears it. A set-mask command writes the three per-line mask bits.

The core signals that it has taken the presented interrupt by pulsing `ack_i`. The block then drops the global enable. If the 7.5 line was the one served, the block also clears its pending flop. Pushing the return address and fetching the routine are left to the core.

Top module: `irq_vector_unit`

## Requirements
- R1: When several qualified sources are active in the same cycle, only the highest is presented. The order from highest to lowest is trap, 7.5, 6.5, 5.5, general request.
- R2: Each fixed source has its own fixed vector: trap 0x0024, 7.5 0x003C, 6.5 0x0034, 5.5 0x002C.
- R3: The trap is presented in the same cycle it is high, whatever the state of the global enable and the masks.
- R4: For the general request the vector is N*8, zero-extended to 16 bits, where N is `rst_num_i`. Every such vector lies below 0x0040.
- R5: An `en_cmd_i` pulse sets the global enable, which is seen from the next cycle on. A `dis_cmd_i` pulse clears it from the next cycle on. When both pulse together, the disable wins.
- R6: A `mask_cmd_i` pulse loads `mask_wdata_i` into the mask, which acts from the next cycle on. Bit 0 blocks 5.5, bit 1 blocks 6.5 and bit 2 blocks 7.5. A bit set to 1 blocks its line.
- R7: After reset, the global enable is 0, all three mask bits are 1 and the 7.5 pending flop is clear. Only the trap can then raise `irq_o`.
- R8: A rising edge on `rst75_i` sets a pending flop one cycle later. This happens even while the line is masked or disabled. The flop stays set after the line falls. It is cleared only when 7.5 is presented and acknowledged.
- R9: An `ack_i` pulse while `irq_o` is high clears the global enable from the next cycle on. It takes precedence over an `en_cmd_i` pulse in the same cycle.
- R10: The 5.5 line, the 6.5 line and the general request are level-sensitive. They are presented only while their input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trap_i | input | 1 | Non-maskable trap request, level |
| rst75_i | input | 1 | Restart 7.5 request, captured on its rising edge |
| rst65_i | input | 1 | Restart 6.5 request, level |
| rst55_i | input | 1 | Restart 5.5 request, level |
| gen_req_i | input | 1 | General request, level |
| rst_num_i | input | 3 | Restart number N for the general request |
| en_cmd_i | input | 1 | Enable command pulse |
| dis_cmd_i | input | 1 | Disable command pulse |
| mask_cmd_i | input | 1 | Set-mask command pulse |
| mask_wdata_i | input | 3 | Mask value to load; 1 blocks the line |
| ack_i | input | 1 | Core takes the presented interrupt |
| irq_o | output | 1 | An interrupt is pending for the core |
| vector_o | output | 16 | Service address of the presented source |

## Verification
Some properties are checked by assertions on every cycle:
- the trap always forces the request and the 0x0024 vector;
- at most one source is granted;
- no maskable source gets through while the global enable is clear;
- general-request vectors stay below 0x0040;
- a disable or an acknowledge leaves the enable clear on the next cycle;
- the 7.5 pending flop holds until it is cleared.

Other behaviours need the bench's ordered scenarios:
- the one-cycle latency of each command;
- the full priority ladder, with all sources active together;
- an edge that is caught while masked and served only after unmasking;
- an acknowledge that clears both the enable and the 7.5 pending flop.

// File: rtl/irqv_pkg.sv
// Shared source indices and fixed vector addresses for the interrupt controller.
package irqv_pkg;
    localparam int NSRC = 5;
    localparam int NMSK = 3;
    localparam int NUMW = 3;

    // Index order is the priority order: a higher index wins.
    localparam int SRC_GEN  = 0;
    localparam int SRC_R55  = 1;
    localparam int SRC_R65  = 2;
    localparam int SRC_R75  = 3;
    localparam int SRC_TRAP = 4;

    localparam logic [7:0] VEC_TRAP = 8'h24;
    localparam logic [7:0] VEC_R55  = 8'h2C;
    localparam logic [7:0] VEC_R65  = 8'h34;
    localparam logic [7:0] VEC_R75  = 8'h3C;
endpackage

// File: rtl/irqv_edge_catch.sv
// Edge catcher: turns a rising edge on a level input into a sticky pending flag.
// The flag is cleared by clr_i. A new edge in the same cycle as a clear wins.
// Assumes lvl_i is already synchronous to clk.
module irqv_edge_catch (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic rise;

    assign rise = lvl_i & ~prev_q;

    // Remember the last level and update the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            if (rise)       pend_o <= 1'b1;
            else if (clr_i) pend_o <= 1'b0;
        end
    end

    a_r8_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pend_o);
    a_r8_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);
endmodule

// File: rtl/irqv_gate_regs.sv
// Gate registers: the global enable bit and the per-line mask.
// Assumes the command inputs are single-cycle pulses. A disable or an
// acknowledge clear takes precedence over an enable.
module irqv_gate_regs
    import irqv_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_cmd_i,
    input  logic            dis_cmd_i,
    input  logic            ack_clr_i,
    input  logic            mask_cmd_i,
    input  logic [NMSK-1:0] mask_wdata_i,
    output logic            gen_en_o,
    output logic [NMSK-1:0] mask_o
);
    // Global enable: clears win over sets.
    always_ff @(posedge clk) begin
        if (!rst_n)                     gen_en_o <= 1'b0;
        else if (dis_cmd_i | ack_clr_i) gen_en_o <= 1'b0;
        else if (en_cmd_i)              gen_en_o <= 1'b1;
    end

    // Mask register: loaded whole by the set-mask command; all lines blocked at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          mask_o <= '1;
        else if (mask_cmd_i) mask_o <= mask_wdata_i;
    end

    a_r5_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        dis_cmd_i |=> !gen_en_o);
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_clr_i |=> !gen_en_o);
    a_r6_mask_loads: assert property (@(posedge clk) disable iff (!rst_n)
        mask_cmd_i |=> (mask_o == $past(mask_wdata_i)));
endmodule

// File: rtl/irqv_arbiter.sv
// Fixed-priority arbiter: picks the highest qualified source and forms its vector.
// Assumes req_i is already gated by the enable and the masks. Purely combinational.
module irqv_arbiter
    import irqv_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [NSRC-1:0]   req_i,
    input  logic [NUMW-1:0]   num_i,
    output logic              any_o,
    output logic [NSRC-1:0]   grant_o,
    output logic [ADDR_W-1:0] vec_o
);
    localparam int PADW = ADDR_W - NUMW - 3;

    // Priority scan: a higher index overrides a lower one.
    always_comb begin
        grant_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i]) grant_o = NSRC'(1) << i;
        end
    end

    assign any_o = |req_i;

    // Vector select from the one-hot grant.
    always_comb begin
        vec_o = '0;
        if (grant_o[SRC_GEN])  vec_o = {{PADW{1'b0}}, num_i, 3'b000};
        if (grant_o[SRC_R55])  vec_o = ADDR_W'(VEC_R55);
        if (grant_o[SRC_R65])  vec_o = ADDR_W'(VEC_R65);
        if (grant_o[SRC_R75])  vec_o = ADDR_W'(VEC_R75);
        if (grant_o[SRC_TRAP]) vec_o = ADDR_W'(VEC_TRAP);
    end
endmodule

// File: rtl/irq_vector_unit.sv
// Top of the prioritized vectored interrupt controller.
// It qualifies the five sources against the enable and the masks, arbitrates,
// and clears state on acknowledge. Assumes all inputs are synchronous to clk.
module irq_vector_unit
    import irqv_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trap_i,
    input  logic                  rst75_i,
    input  logic                  rst65_i,
    input  logic                  rst55_i,
    input  logic                  gen_req_i,
    input  logic [NUMW-1:0]       rst_num_i,
    input  logic                  en_cmd_i,
    input  logic                  dis_cmd_i,
    input  logic                  mask_cmd_i,
    input  logic [NMSK-1:0]       mask_wdata_i,
    input  logic                  ack_i,
    output logic                  irq_o,
    output logic [ADDR_W-1:0]     vector_o
);
    localparam int LOW_W = NUMW + 3;

    logic            gen_en;
    logic [NMSK-1:0] mask;
    logic            pend75;
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] grant;
    logic            ack_take;
    logic            clr75;

    assign ack_take = ack_i & irq_o;
    assign clr75    = ack_take & grant[SRC_R75];

    irqv_gate_regs u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_cmd_i     (en_cmd_i),
        .dis_cmd_i    (dis_cmd_i),
        .ack_clr_i    (ack_take),
        .mask_cmd_i   (mask_cmd_i),
        .mask_wdata_i (mask_wdata_i),
        .gen_en_o     (gen_en),
        .mask_o       (mask)
    );

    irqv_edge_catch u_edge75 (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (rst75_i),
        .clr_i  (clr75),
        .pend_o (pend75)
    );

    // Qualify each source with the enable and its mask bit; the trap bypasses both.
    always_comb begin
        req           = '0;
        req[SRC_GEN]  = gen_en & gen_req_i;
        req[SRC_R55]  = gen_en & ~mask[0] & rst55_i;
        req[SRC_R65]  = gen_en & ~mask[1] & rst65_i;
        req[SRC_R75]  = gen_en & ~mask[2] & pend75;
        req[SRC_TRAP] = trap_i;
    end

    irqv_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .req_i   (req),
        .num_i   (rst_num_i),
        .any_o   (irq_o),
        .grant_o (grant),
        .vec_o   (vector_o)
    );

    a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r3_trap_forces: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i |-> (irq_o && vector_o == ADDR_W'(VEC_TRAP)));
    a_r7_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && !trap_i) |-> !irq_o);
    a_r4_low_page: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && grant[SRC_GEN]) |-> (vector_o[ADDR_W-1:LOW_W] == '0 && vector_o[2:0] == 3'b000));
endmodule

// File: tb/sim_irq_vector_unit.sv
// Scoreboard bench: the driver queues expected outputs and the monitor compares them.
module sim_irq_vector_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap = 0, r75 = 0, r65 = 0, r55 = 0, gen = 0;
    logic [2:0]  num = 0, mwd = 0;
    logic        en_c = 0, dis_c = 0, sm_c = 0, ack = 0;
    logic        irq;
    logic [15:0] vec;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    typedef struct {
        logic        e_irq;
        logic [15:0] e_vec;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    always #5 clk = ~clk;

    irq_vector_unit u0 (
        .clk(clk), .rst_n(rst_n), .trap_i(trap), .rst75_i(r75), .rst65_i(r65),
        .rst55_i(r55), .gen_req_i(gen), .rst_num_i(num), .en_cmd_i(en_c),
        .dis_cmd_i(dis_c), .mask_cmd_i(sm_c), .mask_wdata_i(mwd), .ack_i(ack),
        .irq_o(irq), .vector_o(vec)
    );

    // Advance to the next falling edge and drop all command pulses.
    task automatic tick();
        @(negedge clk);
        en_c = 0; dis_c = 0; sm_c = 0; ack = 0;
    endtask

    task automatic expect_out(input logic ei, input logic [15:0] ev, input string tag);
        exp_t e;
        e.e_irq = ei; e.e_vec = ev; e.tag = tag;
        sbq.push_back(e);
    endtask

    // Monitor: compare queued expectations shortly after each falling edge.
    always begin
        @(negedge clk);
        #3;
        while (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            n_chk++;
            if (irq !== e.e_irq || (e.e_irq && vec !== e.e_vec)) begin
                n_bad++;
                $display("FAIL %s: irq=%0b vec=%h expected irq=%0b vec=%h",
                         e.tag, irq, vec, e.e_irq, e.e_vec);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        tick(); expect_out(0, 16'h0, "R7 idle after reset");
        tick(); gen = 1; num = 5; expect_out(0, 16'h0, "R7 enable clear after reset");
        tick(); trap = 1; expect_out(1, 16'h0024, "R3 trap while disabled");
        tick(); trap = 0; en_c = 1; expect_out(0, 16'h0, "R5 enable not yet active");
        tick(); expect_out(1, 16'h0028, "R4 general N=5");
        tick(); num = 0; expect_out(1, 16'h0000, "R4 general N=0");
        tick(); num = 7; expect_out(1, 16'h0038, "R4 general N=7");
        tick(); r55 = 1; expect_out(1, 16'h0038, "R7 reset mask blocks 5.5");
        tick(); sm_c = 1; mwd = 3'b000; expect_out(1, 16'h0038, "R6 mask not yet loaded");
        tick(); expect_out(1, 16'h002C, "R1 5.5 over general");
        tick(); r65 = 1; expect_out(1, 16'h0034, "R1 6.5 over 5.5");
        tick(); r75 = 1; expect_out(1, 16'h0034, "R8 edge not yet pending");
        tick(); expect_out(1, 16'h003C, "R2 7.5 vector");
        tick(); r75 = 0; expect_out(1, 16'h003C, "R8 pending held after fall");
        tick(); trap = 1; expect_out(1, 16'h0024, "R1 trap highest");
        tick(); trap = 0; ack = 1; expect_out(1, 16'h003C, "R9 ack cycle");
        tick(); expect_out(0, 16'h0, "R9 ack clears enable");
        tick(); en_c = 1; expect_out(0, 16'h0, "R5 re-enable latency");
        tick(); expect_out(1, 16'h0034, "R8 pending cleared by ack");
        tick(); sm_c = 1; mwd = 3'b010; expect_out(1, 16'h0034, "R6 before mask");
        tick(); expect_out(1, 16'h002C, "R6 6.5 masked");
        tick(); r55 = 0; expect_out(1, 16'h0038, "R10 5.5 level drop");
        tick(); en_c = 1; dis_c = 1; expect_out(1, 16'h0038, "R5 both commands cycle");
        tick(); expect_out(0, 16'h0, "R5 disable wins");
        tick(); gen = 0; r65 = 0; sm_c = 1; mwd = 3'b111; en_c = 1; expect_out(0, 16'h0, "R6 setup");
        tick(); r75 = 1; expect_out(0, 16'h0, "R8 edge while masked");
        tick(); r75 = 0; expect_out(0, 16'h0, "R6 7.5 masked");
        tick(); sm_c = 1; mwd = 3'b000; expect_out(0, 16'h0, "R6 unmask latency");
        tick(); expect_out(1, 16'h003C, "R8 pending kept while masked");
        tick(); ack = 1; en_c = 1; expect_out(1, 16'h003C, "R9 ack with enable");
        tick(); expect_out(0, 16'h0, "R9 ack wins over enable");
        tick(); en_c = 1; expect_out(0, 16'h0, "R5 re-enable");
        tick(); expect_out(0, 16'h0, "R8 pending gone");
        tick(); r55 = 1; expect_out(1, 16'h002C, "R10 5.5 level high");
        tick(); r55 = 0; expect_out(0, 16'h0, "R10 5.5 level low");
        tick(); tick();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule